// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a two-wire serial slave engine and a 128-byte non-volatile storage array. While a write command is in flight, the engine first loads the word address. It then hands over each received data byte. The block keeps those bytes in a 16-entry page buffer, each entry tagged by its offset inside the page. The offset pointer advances only in its low four bits, so a long burst wraps back to the start of the same page. Once the burst is longer than a page, the newer bytes replace the older ones.

When the engine sees a valid Stop after a write command, it pulses the commit strobe. If at least one byte is buffered, the block runs a self-timed write cycle of a fixed number of clock cycles. During that cycle it drives every buffered byte onto the array's write port, one byte per clock. The busy output stays high for the whole cycle, and the engine uses it to withhold acknowledges.

A write-protect level, sampled at commit, blocks every write into the upper half of the array. The full cycle time still elapses when writes are blocked. An abort strobe empties the buffer without starting a cycle. The engine uses it for a Stop that carried no data, or for a repeated Start used to set up a random read.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy and wr_en are low.
- R2: addr_load takes the page from addr_in[6:4] and the offset from addr_in[3:0]. Each accepted push stores push_data at the current offset and then increments only the 4-bit offset, so address 1Fh is followed by 10h. The page bits never change on a push.
- R3: When more than 16 bytes are pushed into one page, each new byte replaces the byte that was buffered at the same offset. After the cycle, the array holds only the last 16 bytes.
- R4: A commit while idle, with at least one buffered byte, raises busy on the next clock edge. A commit with an empty buffer leaves busy low.
- R5: Once raised, busy stays high for exactly WR_CYCLES clock cycles.
- R6: During the cycle, buffered entries are presented with wr_en high in ascending offset order, one per clock, starting with offset 0 in the first busy cycle. Offsets that were never pushed are not written. All entries are emptied when the cycle ends, so a later commit with no new push starts no cycle.
- R7: When wp is high at the commit and the page lies in 40h–7Fh (addr bit 6 set), no byte is written, yet busy still lasts WR_CYCLES cycles. With wp low, or with a page in 00h–3Fh, the bytes are written.
- R8: An abort while idle empties the buffer. A following commit with no new push starts no cycle, and only bytes pushed after the abort are written by a later cycle. Abort takes priority over a commit in the same cycle.
- R9: While busy is high, addr_load, push, commit and abort are ignored. They do not alter the bytes written, the array, or the state after the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe: load page and offset from addr_in |
| addr_in | input | 7 | Word address of the first byte |
| push | input | 1 | Strobe: buffer push_data at the current offset |
| push_data | input | 8 | Data byte to buffer |
| commit | input | 1 | Strobe: valid Stop after a write, start the cycle |
| abort | input | 1 | Strobe: drop buffered bytes without a cycle |
| wp | input | 1 | Write-protect level for the upper half |
| wr_en | output | 1 | Array write enable |
| wr_addr | output | 7 | Array write address |
| wr_data | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |

## Verification
The assertions assume that each strobe lasts a single clock and that the engine drives addr_load before the pushes of a burst. They also assume that wp is settled by the time commit is sampled. The bench drives every strobe for exactly one clock period between falling edges and changes wp only while no strobe is active. It also issues strobes during busy on purpose, because the block must ignore them there. The bench models the array from the write port alone, then compares all 128 locations against an expected image that it builds from the requirements.

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int OFS_W     = 4,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              commit,
  input  logic              abort,
  input  logic              wp,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy
);
  localparam int DEPTH = 1 << OFS_W;
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [PG_W-1:0]   page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic              busy_q;
  logic              prot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OFS_W:0]    scan_q;

  logic take_push;
  assign take_push = !busy_q && push && !abort && !commit && !addr_load;

  always_ff @(posedge clk) begin
    if (take_push) data_q[ofs_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
      vld_q  <= '0;
      busy_q <= 1'b0;
      prot_q <= 1'b0;
      cnt_q  <= '0;
      scan_q <= '0;
    end else if (!busy_q) begin
      if (abort) begin
        vld_q <= '0;
      end else if (commit) begin
        if (|vld_q) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(WR_CYCLES - 1);
          scan_q <= '0;
          prot_q <= wp && page_q[PG_W-1];
        end
      end else if (addr_load) begin
        page_q <= addr_in[ADDR_W-1:OFS_W];
        ofs_q  <= addr_in[OFS_W-1:0];
      end else if (push) begin
        vld_q[ofs_q] <= 1'b1;
        ofs_q        <= ofs_q + 1'b1;
      end
    end else begin
      if (!scan_q[OFS_W]) scan_q <= scan_q + 1'b1;
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        vld_q  <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign wr_en   = busy_q && !scan_q[OFS_W] && vld_q[scan_q[OFS_W-1:0]] && !prot_q;
  assign wr_addr = {page_q, scan_q[OFS_W-1:0]};
  assign wr_data = data_q[scan_q[OFS_W-1:0]];
  assign busy    = busy_q;

  a_r4_rise_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(commit) && !$past(abort)));

  a_r6_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy_q);

  a_r7_protected_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && $past(wp) && page_q[PG_W-1]) |-> !wr_en);

  a_r9_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(page_q));

  a_r2_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    take_push |=> (ofs_q == OFS_W'($past(ofs_q) + 1'b1)));

  a_r5_end_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == '0));
endmodule

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
  localparam int WR = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0, push = 1'b0, commit = 1'b0, abort = 1'b0, wp = 1'b0;
  logic [6:0] addr_in = '0;
  logic [7:0] push_data = '0;
  logic       wr_en, busy;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  page_write_buffer #(.WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .push(push), .push_data(push_data), .commit(commit), .abort(abort), .wp(wp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy));

  always #5 clk = ~clk;

  logic [7:0] mem [128];
  logic [7:0] exp_m [128];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [6:0] a);
    @(negedge clk); addr_in = a; addr_load = 1'b1;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic do_push(input logic [7:0] d);
    @(negedge clk); push_data = d; push = 1'b1;
    @(negedge clk); push = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  task automatic do_commit(input bit expect_cycle, input string req);
    int n;
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    chk(busy == expect_cycle, req, busy, expect_cycle);
    if (expect_cycle) begin
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk(n == WR, {req, " busy length (R5)"}, n, WR);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < 128; i++) if (mem[i] !== exp_m[i] && bad < 0) bad = i;
    if (bad >= 0) chk(1'b0, {req, " array"}, {bad, mem[bad]}, {bad, exp_m[bad]});
    else chk(1'b1, req, 0, 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(wr_en == 1'b0, "R1 wr_en", wr_en, 0);
  endtask

  task automatic t_basic();
    do_load(7'h05);
    do_push(8'hA1); do_push(8'hB2); do_push(8'hC3);
    exp_m[5] = 8'hA1; exp_m[6] = 8'hB2; exp_m[7] = 8'hC3;
    do_commit(1, "R4 start");
    cmp_mem("R2 R6 basic");
  endtask

  task automatic t_wrap();
    do_load(7'h1E);
    do_push(8'h11); do_push(8'h22); do_push(8'h33); do_push(8'h44);
    exp_m[7'h1E] = 8'h11; exp_m[7'h1F] = 8'h22; exp_m[7'h10] = 8'h33; exp_m[7'h11] = 8'h44;
    do_commit(1, "R2 wrap start");
    cmp_mem("R2 wrap");
  endtask

  task automatic t_overflow();
    do_load(7'h20);
    for (int i = 0; i < 20; i++) begin
      do_push(8'(8'h60 + i));
      exp_m[7'h20 + (i % 16)] = 8'(8'h60 + i);
    end
    do_commit(1, "R3 start");
    cmp_mem("R3 last sixteen");
  endtask

  task automatic t_protect();
    wp = 1'b1;
    do_load(7'h50);
    do_push(8'hDE); do_push(8'hAD);
    do_commit(1, "R7 protected start");
    cmp_mem("R7 protected unchanged");
    do_load(7'h12);
    do_push(8'h5A);
    exp_m[7'h12] = 8'h5A;
    do_commit(1, "R7 lower half start");
    cmp_mem("R7 lower half written");
    wp = 1'b0;
    do_load(7'h55);
    do_push(8'h77);
    exp_m[7'h55] = 8'h77;
    do_commit(1, "R7 wp low start");
    cmp_mem("R7 wp low written");
  endtask

  task automatic t_empty();
    do_commit(0, "R6 emptied after cycle");
    do_load(7'h08);
    do_commit(0, "R4 empty commit");
    cmp_mem("R4 empty commit array");
  endtask

  task automatic t_abort();
    do_load(7'h30);
    do_push(8'h91); do_push(8'h92);
    do_abort();
    do_commit(0, "R8 abort then commit");
    do_load(7'h31);
    do_push(8'h93);
    exp_m[7'h31] = 8'h93;
    do_commit(1, "R8 new data start");
    cmp_mem("R8 only new data");
    do_load(7'h3A);
    do_push(8'h94);
    @(negedge clk); abort = 1'b1; commit = 1'b1;
    @(negedge clk); abort = 1'b0; commit = 1'b0;
    chk(busy == 1'b0, "R8 abort beats commit", busy, 0);
    do_commit(0, "R8 abort beats commit empty");
    cmp_mem("R8 abort beats commit array");
  endtask

  task automatic t_busy_ignore();
    do_load(7'h60);
    do_push(8'hE1);
    exp_m[7'h60] = 8'hE1;
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    chk(busy == 1'b1, "R9 cycle running", busy, 1);
    addr_in = 7'h70; addr_load = 1'b1;
    @(negedge clk); addr_load = 1'b0; push_data = 8'hAA; push = 1'b1;
    @(negedge clk); push_data = 8'hBB;
    @(negedge clk); push = 1'b0; commit = 1'b1;
    @(negedge clk); commit = 1'b0; abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    while (busy) @(negedge clk);
    cmp_mem("R9 strobes during busy");
    do_commit(0, "R9 nothing buffered during busy");
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin mem[i] = 8'h00; exp_m[i] = 8'h00; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_overflow();
    t_protect();
    t_empty();
    t_abort();
    t_busy_ignore();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule